// File: doc/BRIEF.md
# Over-Current Trip and Gate Qualifier

This block sits between a PWM generator and the gate drive stages of a power switch pair. For each channel it takes a PWM command, the digitized output of an over-current comparator and a supply-fault level. From these it produces a qualified gate-enable, a control that shorts the current-sense input while readings cannot be trusted, and a fixed-width pulse that tells the fault-reporting path that an over-current trip took place.

A trip kills the gate for the rest of the PWM period. The channel recovers only on the next rising command edge. Right after each turn-on, the sense input is held shorted and the comparator is ignored for a fixed blanking window. A PWM period that begins while a fault is present is dropped as a whole. Each channel has its own supply-fault input, which stops only that channel. One shared primary-side fault input stops every channel. The comparator and fault inputs pass through two-flop synchronizers. The PWM command is taken as already synchronous to the clock.

Top module: `oc_trip_guard`

## Requirements
- R1: A synchronous reset drives every gate-enable and fault pulse low and every sense-short output high. A command that is already high when reset is released does not start a period, so the gate stays low until the command's next rising edge.
- R2: A rising command edge with no fault present turns the gate on at the next clock edge. A low command turns the gate off at the next clock edge.
- R3: Sense-short is high whenever the gate is off and for the first BLANK_CYCLES cycles after the gate turns on. During that time the comparator has no effect, even if it is asserted and then released inside the window.
- R4: A comparator assertion seen outside the blanking window turns the gate off. The gate falls at the third clock edge after the raw input changes, because of the two-flop synchronizer and the registered gate. A comparator held asserted through blanking trips at the edge right after the window ends.
- R5: After a trip the gate stays off for the rest of the period, even after the comparator clears and is asserted again.
- R6: The next rising command edge after a trip turns the gate on again.
- R7: Each trip produces exactly one fault pulse, high for PULSE_CYCLES cycles and starting on the edge where the gate falls. A renewed comparator assertion in the same period produces no second pulse.
- R8: A fault that is present when the command rises drops that whole period, even if the fault clears while the command is still high. The next period after the fault clears runs normally.
- R9: A channel's own supply fault, once synchronized, turns off only that channel, at the third edge after the input rises. It produces no fault pulse.
- R10: The primary-side fault input turns off all channels at the third edge after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwmCmd | input | NUM_CH | PWM command per channel, synchronous to clk |
| ocRaw | input | NUM_CH | Over-current comparator output per channel, asynchronous |
| secFault | input | NUM_CH | Per-channel supply fault level, asynchronous |
| priFault | input | 1 | Shared primary-side fault level, asynchronous |
| gateEn | output | NUM_CH | Qualified gate enable per channel |
| senseGnd | output | NUM_CH | High while the sense input is to be held shorted |
| faultPulse | output | NUM_CH | Fixed-width over-current report pulse per channel |

## Verification
The bench sweeps the cycle in which the comparator rises, from the cycle of turn-on to beyond the end of blanking, and on both channels. This catches a blanking window that is off by one, because the gate would then fall one edge early or late against the arithmetic fall edge. It also catches a design that keeps the comparator masked for good, because the gate would never fall. A comparator that asserts and releases inside the window must leave the gate on. A re-asserted comparator after a trip must not re-enable the gate or fire a second pulse. A fault that clears in the middle of a period must not revive that period. A per-channel fault that wrongly reached the other channel would show up as a lost gate on the healthy channel.

// File: rtl/oc_trip_pkg.sv
package oc_trip_pkg;

  // Strobes issued by the per-channel control to its datapath.
  typedef struct packed {
    logic gateSet;    // gate turns on at this edge
    logic gateClr;    // gate turns (or stays) off at this edge
    logic pulseLoad;  // over-current trip: start a report pulse
  } ctrlStrobe_t;

endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageA;
  logic [WIDTH-1:0] stageB;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageA <= '0;
      stageB <= '0;
    end else begin
      stageA <= asyncIn;
      stageB <= stageA;
    end
  end

  assign syncOut = stageB;

endmodule

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_trip_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        pwmCmd,
  input  logic        ocSync,
  input  logic        faultSync,
  input  logic        blankDone,
  output logic        gateQ,
  output ctrlStrobe_t strobe
);

  logic pwmPrev;
  logic cmdRise;
  logic tripNow;

  // pwmPrev resets high: a command already high at reset release is not a new period.
  always_ff @(posedge clk) begin
    if (rst) pwmPrev <= 1'b1;
    else     pwmPrev <= pwmCmd;
  end

  assign cmdRise = pwmCmd & ~pwmPrev;
  assign tripNow = gateQ & blankDone & ocSync;

  always_comb begin
    strobe           = '0;
    strobe.gateSet   = cmdRise & ~faultSync;
    strobe.gateClr   = ~pwmCmd
                     | (cmdRise & faultSync)
                     | (~cmdRise & (faultSync | tripNow));
    strobe.pulseLoad = tripNow;
  end

  always_ff @(posedge clk) begin
    if (rst)                 gateQ <= 1'b0;
    else if (strobe.gateClr) gateQ <= 1'b0;
    else if (strobe.gateSet) gateQ <= 1'b1;
  end

endmodule

// File: rtl/oc_dpath.sv
module oc_dpath
  import oc_trip_pkg::*;
#(
  parameter int BLANK_CYCLES = 350,
  parameter int PULSE_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        gateQ,
  input  ctrlStrobe_t strobe,
  output logic        blankDone,
  output logic        senseGnd,
  output logic        faultPulse
);

  localparam int BLANK_W = $clog2(BLANK_CYCLES + 1);
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [BLANK_W-1:0] BLANK_END = BLANK_W'(BLANK_CYCLES);
  localparam logic [PULSE_W-1:0] PULSE_LEN = PULSE_W'(PULSE_CYCLES);

  logic [BLANK_W-1:0] blankCnt;
  logic [PULSE_W-1:0] pulseCnt;

  // Counts on-cycles since turn-on, saturating at the end of blanking.
  always_ff @(posedge clk) begin
    if (rst || strobe.gateSet || strobe.gateClr) blankCnt <= '0;
    else if (gateQ && blankCnt != BLANK_END)     blankCnt <= blankCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                   pulseCnt <= '0;
    else if (strobe.pulseLoad) pulseCnt <= PULSE_LEN;
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
  end

  assign blankDone  = gateQ && (blankCnt == BLANK_END);
  assign senseGnd   = ~blankDone;
  assign faultPulse = (pulseCnt != '0);

endmodule

// File: rtl/oc_trip_guard.sv
module oc_trip_guard
  import oc_trip_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int BLANK_CYCLES = 350,
  parameter int PULSE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pwmCmd,
  input  logic [NUM_CH-1:0] ocRaw,
  input  logic [NUM_CH-1:0] secFault,
  input  logic              priFault,
  output logic [NUM_CH-1:0] gateEn,
  output logic [NUM_CH-1:0] senseGnd,
  output logic [NUM_CH-1:0] faultPulse
);

  localparam int SYNC_W = 2 * NUM_CH + 1;

  logic [SYNC_W-1:0] syncIn;
  logic [SYNC_W-1:0] syncOut;
  logic [NUM_CH-1:0] ocSync;
  logic [NUM_CH-1:0] secSync;
  logic              priSync;

  assign syncIn = {priFault, secFault, ocRaw};

  oc_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(syncIn),
    .syncOut(syncOut)
  );

  assign ocSync  = syncOut[NUM_CH-1:0];
  assign secSync = syncOut[2*NUM_CH-1:NUM_CH];
  assign priSync = syncOut[SYNC_W-1];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ctrlStrobe_t strobe;
    logic        gateQ;
    logic        blankDone;

    oc_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .pwmCmd   (pwmCmd[ch]),
      .ocSync   (ocSync[ch]),
      .faultSync(secSync[ch] | priSync),
      .blankDone(blankDone),
      .gateQ    (gateQ),
      .strobe   (strobe)
    );

    oc_dpath #(
      .BLANK_CYCLES(BLANK_CYCLES),
      .PULSE_CYCLES(PULSE_CYCLES)
    ) u_dpath (
      .clk       (clk),
      .rst       (rst),
      .gateQ     (gateQ),
      .strobe    (strobe),
      .blankDone (blankDone),
      .senseGnd  (senseGnd[ch]),
      .faultPulse(faultPulse[ch])
    );

    assign gateEn[ch] = gateQ;
  end

endmodule

// File: rtl/oc_trip_guard_chk.sv
module oc_trip_guard_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] pwmCmd,
  input logic [NUM_CH-1:0] gateEn,
  input logic [NUM_CH-1:0] senseGnd,
  input logic [NUM_CH-1:0] faultPulse
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R2: a low command leaves the gate off after the next edge
    assert_cmd_low_gate_off_R2: assert property (@(posedge clk) disable iff (rst)
      !pwmCmd[ch] |=> !gateEn[ch]);

    // R3: sense stays shorted whenever the gate is off
    assert_sense_when_off_R3: assert property (@(posedge clk) disable iff (rst)
      !gateEn[ch] |-> senseGnd[ch]);

    // R3: the first on-cycle is always inside blanking
    assert_sense_at_turn_on_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(gateEn[ch]) |-> senseGnd[ch]);

    // R5: an off gate under a steady high command stays off
    assert_trip_holds_R5: assert property (@(posedge clk) disable iff (rst)
      (!gateEn[ch] && pwmCmd[ch] && $past(pwmCmd[ch])) |=> !gateEn[ch]);

    // R7: a report pulse begins only on the edge where the gate drops
    assert_pulse_with_trip_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(faultPulse[ch]) |-> $fell(gateEn[ch]));
  end

endmodule

bind oc_trip_guard oc_trip_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwmCmd    (pwmCmd),
  .gateEn    (gateEn),
  .senseGnd  (senseGnd),
  .faultPulse(faultPulse)
);

// File: tb/oc_trip_guard_tb.sv
module oc_trip_guard_tb;

  localparam int NCH = 2;
  localparam int BL  = 5;
  localparam int PW  = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] pwmCmd = '0;
  logic [NCH-1:0] ocRaw = '0;
  logic [NCH-1:0] secFault = '0;
  logic           priFault = 1'b0;
  logic [NCH-1:0] gateEn;
  logic [NCH-1:0] senseGnd;
  logic [NCH-1:0] faultPulse;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  oc_trip_guard #(
    .NUM_CH(NCH), .BLANK_CYCLES(BL), .PULSE_CYCLES(PW)
  ) u_dut (
    .clk(clk), .rst(rst), .pwmCmd(pwmCmd), .ocRaw(ocRaw),
    .secFault(secFault), .priFault(priFault),
    .gateEn(gateEn), .senseGnd(senseGnd), .faultPulse(faultPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    step(3);
    chk("R1 gate in reset", 32'(gateEn), 0);
    chk("R1 pulse in reset", 32'(faultPulse), 0);
    chk("R1 sense in reset", 32'(senseGnd), 32'(2**NCH - 1));
    rst = 1'b0;
    step(2);

    // R3/R4/R7 sweep: comparator rises d cycles after turn-on
    for (int ch = 0; ch < NCH; ch++) begin
      for (int d = 0; d <= BL + 2; d++) begin
        int fall;
        fall = (d + 3 > BL + 1) ? d + 3 : BL + 1;
        pwmCmd[ch] = 1'b1;
        step();
        for (int j = 0; j < fall + PW + 2; j++) begin
          logic eg;
          if (j == d) ocRaw[ch] = 1'b1;
          eg = (j < fall);
          chk("R4 gate vs trip edge", 32'(gateEn[ch]), 32'(eg));
          chk("R3 sense blanking", 32'(senseGnd[ch]), 32'(!(eg && j >= BL)));
          chk("R7 pulse width", 32'(faultPulse[ch]), 32'(j >= fall && j < fall + PW));
          chk("R9 other channel idle", 32'(gateEn[1-ch]), 0);
          step();
        end
        ocRaw[ch] = 1'b0;
        step(4);
        chk("R5 trip held after release", 32'(gateEn[ch]), 0);
        ocRaw[ch] = 1'b1;
        for (int j = 0; j < BL + 4; j++) begin
          step();
          chk("R5 trip held on re-assert", 32'(gateEn[ch]), 0);
          chk("R7 no second pulse", 32'(faultPulse[ch]), 0);
        end
        ocRaw[ch] = 1'b0;
        pwmCmd[ch] = 1'b0;
        step(3);
        pwmCmd[ch] = 1'b1;
        step();
        chk("R6 resume on next rise", 32'(gateEn[ch]), 1);
        pwmCmd[ch] = 1'b0;
        step();
        chk("R2 gate off after low cmd", 32'(gateEn[ch]), 0);
        step(2);
      end
    end

    // R3: short comparator glitch inside blanking is ignored
    pwmCmd[0] = 1'b1;
    step();
    ocRaw[0] = 1'b1;
    step();
    ocRaw[0] = 1'b0;
    for (int j = 0; j < BL + 4; j++) begin
      chk("R3 glitch in blanking ignored", 32'(gateEn[0]), 1);
      chk("R3 no pulse from glitch", 32'(faultPulse[0]), 0);
      step();
    end
    pwmCmd[0] = 1'b0;
    step(2);

    // R8: fault present at period start drops the whole period
    secFault[0] = 1'b1;
    step(3);
    pwmCmd[0] = 1'b1;
    step();
    chk("R8 vetoed start", 32'(gateEn[0]), 0);
    secFault[0] = 1'b0;
    for (int j = 0; j < 4; j++) begin
      step();
      chk("R8 stays dropped after clear", 32'(gateEn[0]), 0);
    end
    pwmCmd[0] = 1'b0;
    step();
    pwmCmd[0] = 1'b1;
    step();
    chk("R8 next period runs", 32'(gateEn[0]), 1);
    pwmCmd[0] = 1'b0;
    step(2);

    // R9: channel fault affects only its own channel
    pwmCmd = '1;
    step();
    chk("R2 both on", 32'(gateEn), 3);
    secFault[1] = 1'b1;
    step();
    chk("R9 ch1 still on edge1", 32'(gateEn[1]), 1);
    step();
    chk("R9 ch1 still on edge2", 32'(gateEn[1]), 1);
    step();
    chk("R9 ch1 off edge3", 32'(gateEn[1]), 0);
    chk("R9 ch0 unaffected", 32'(gateEn[0]), 1);
    chk("R9 no pulse on fault", 32'(faultPulse), 0);
    secFault[1] = 1'b0;
    pwmCmd = '0;
    step(4);

    // R10: primary fault stops all channels
    pwmCmd = '1;
    step();
    priFault = 1'b1;
    step(2);
    chk("R10 still on edge2", 32'(gateEn), 3);
    step();
    chk("R10 all off edge3", 32'(gateEn), 0);
    priFault = 1'b0;
    pwmCmd = '0;
    step(4);

    // R1: reset mid-period, command held through release
    pwmCmd[0] = 1'b1;
    step();
    chk("R2 on before reset", 32'(gateEn[0]), 1);
    rst = 1'b1;
    step();
    chk("R1 reset clears gate", 32'(gateEn[0]), 0);
    rst = 1'b0;
    step(3);
    chk("R1 held command not a new period", 32'(gateEn[0]), 0);
    pwmCmd[0] = 1'b0;
    step();
    pwmCmd[0] = 1'b1;
    step();
    chk("R1 fresh rise after reset", 32'(gateEn[0]), 1);
    pwmCmd[0] = 1'b0;
    step(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule